// File: doc/BRIEF.md
# Configuration File Header Skipper

This block sits in front of a configuration loader. It takes the raw bytes of a configuration file on a valid/ready byte stream and removes everything ahead of the configuration payload. It throws away a fixed-size prefix. It then walks across a chain of text fields. Each field opens with a length byte that gives the distance to the next field. Once past the last field, the block hunts byte by byte for a run of sync bytes that marks the payload.

When the run is found, the block sends the sync bytes it has held back and then passes every later byte of the file through unchanged, with backpressure. While the payload moves, it also presents the byte index at which the payload starts. If a file ends before the sync run appears, the block raises a sticky error flag, sends nothing from that file, and waits for the next file.

The block is fully streaming and needs no file-sized storage. The sync bytes it holds back are all the same value, so a counter records them.

Top module: `header_skipper`

## Requirements
- R1: No byte of a file is presented on the output before the sync run of that file is complete, and nothing is presented for a file that has no sync run.
- R2: The first PREFIX_LEN bytes (default 15) are discarded. Each field starts with a length byte L and takes L+FIELD_EXTRA bytes in total (default L+3), so the next field starts L+3 bytes after it. L is unsigned, 0 to 255. Bytes equal to the sync value inside the prefix or inside a field are never taken as part of the sync run.
- R3: Exactly NUM_FIELDS (default 4) length-prefixed fields are skipped back to back. The search for the sync run begins at the byte right after the last field.
- R4: The sync run is SYNC_LEN (default 4) consecutive bytes equal to SYNC_BYTE (default 0xFF). A byte with any other value restarts the count. A longer run is matched at its earliest SYNC_LEN bytes.
- R5: From the first byte of the sync run to the end of the file, every byte is presented on the output once, unchanged and in order, and that includes the sync bytes.
- R6: While payload bytes are presented, offsetValid is 1 and startOffset holds the zero-based index of the first sync byte within the file.
- R7: If the last byte of a file is accepted before a sync run completes, noPreamble goes to 1 and stays at 1 until reset. The next file is then processed normally.
- R8: While outValid is 1 and outReady is 0, outData and outLast hold their values and outValid stays 1. During pass-through, inReady follows outReady, so no byte is lost or repeated.
- R9: outLast is 1 on the final forwarded byte of a file, including the case where the file ends on the last sync byte. After that byte the block accepts input again with the byte index reset to 0 and offsetValid at 0.
- R10: After reset, inReady is 1 and outValid, offsetValid and noPreamble are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 8 | Input file byte |
| inValid | input | 1 | Input byte valid |
| inLast | input | 1 | Input byte is the last byte of the file |
| inReady | output | 1 | Block accepts the input byte |
| outData | output | 8 | Forwarded byte |
| outValid | output | 1 | Forwarded byte valid |
| outLast | output | 1 | Forwarded byte is the last byte of the file |
| outReady | input | 1 | Downstream accepts the forwarded byte |
| startOffset | output | OFF_W (24) | Index of the first sync byte in the current file |
| offsetValid | output | 1 | startOffset is valid and payload is flowing |
| noPreamble | output | 1 | Sticky flag: a file ended without a sync run |

## Verification
The bench builds the block with its default parameters: a 15-byte prefix, four fields with three bytes of overhead each, a run of four 0xFF bytes and a 24-bit offset. With these values a single field can set its length byte to 255, which loads the largest count the skip counter holds. Headers filled with 0xFF show that sync-valued bytes inside skipped fields are ignored. Other test files cover a false run broken by one byte, a run longer than four, a file that ends on the last sync byte, a file that ends while the block is still scanning and a file that ends inside the prefix. The stall patterns on outReady and the gaps on inValid exercise the held-back sync bytes and the pass-through path under backpressure.

// File: rtl/header_skipper_pkg.sv
package header_skipper_pkg;

  typedef enum logic [2:0] {
    ST_SKIP  = 3'd0,
    ST_LEN   = 3'd1,
    ST_SCAN  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_PASS  = 3'd4
  } skipState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;    // reload prefix count, clear field and run counts
    logic loadField;  // load skip count from the length byte
    logic skipDec;
    logic runInc;
    logic runClr;
    logic capture;    // sync run complete: latch offset, arm held bytes
    logic pendDec;
    logic posStep;
    logic posClr;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic skipOne;
    logic fieldsDone;
    logic runAtEnd;
    logic pendOne;
    logic lastPend;
  } dpStat_t;

endpackage

// File: rtl/hs_datapath.sv
module hs_datapath
  import header_skipper_pkg::*;
#(
  parameter int PREFIX_LEN  = 15,
  parameter int NUM_FIELDS  = 4,
  parameter int FIELD_EXTRA = 3,
  parameter int SYNC_LEN    = 4,
  parameter int OFF_W       = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       inData,
  input  logic             inLast,
  input  dpCtrl_t          ctrl,
  output dpStat_t          stat,
  output logic [OFF_W-1:0] startOffset
);

  localparam int LEN_MAX  = 255 + FIELD_EXTRA - 1;
  localparam int SKIP_MAX = (PREFIX_LEN > LEN_MAX) ? PREFIX_LEN : LEN_MAX;
  localparam int SKIP_W   = $clog2(SKIP_MAX + 1);
  localparam int FLD_W    = $clog2(NUM_FIELDS + 1);
  localparam int RUN_W    = $clog2(SYNC_LEN);
  localparam int PEND_W   = $clog2(SYNC_LEN + 1);

  logic [SKIP_W-1:0] skipCnt;
  logic [FLD_W-1:0]  fieldCnt;
  logic [RUN_W-1:0]  runCnt;
  logic [PEND_W-1:0] pendCnt;
  logic              lastPend;
  logic [OFF_W-1:0]  pos;

  // header walk: remaining bytes to drop and fields consumed
  always_ff @(posedge clk) begin
    if (rst) begin
      skipCnt  <= SKIP_W'(PREFIX_LEN);
      fieldCnt <= '0;
    end else if (ctrl.restart) begin
      skipCnt  <= SKIP_W'(PREFIX_LEN);
      fieldCnt <= '0;
    end else if (ctrl.loadField) begin
      skipCnt  <= SKIP_W'(inData) + SKIP_W'(FIELD_EXTRA - 1);
      fieldCnt <= fieldCnt + FLD_W'(1);
    end else if (ctrl.skipDec) begin
      skipCnt  <= skipCnt - SKIP_W'(1);
    end
  end

  // sync run length
  always_ff @(posedge clk) begin
    if (rst || ctrl.restart || ctrl.runClr) runCnt <= '0;
    else if (ctrl.runInc)                   runCnt <= runCnt + RUN_W'(1);
  end

  // held-back sync bytes and the offset of the run
  always_ff @(posedge clk) begin
    if (rst) begin
      pendCnt     <= '0;
      lastPend    <= 1'b0;
      startOffset <= '0;
    end else if (ctrl.capture) begin
      pendCnt     <= PEND_W'(SYNC_LEN);
      lastPend    <= inLast;
      startOffset <= pos - OFF_W'(SYNC_LEN - 1);
    end else if (ctrl.pendDec) begin
      pendCnt     <= pendCnt - PEND_W'(1);
    end
  end

  // byte index inside the current file
  always_ff @(posedge clk) begin
    if (rst || ctrl.posClr) pos <= '0;
    else if (ctrl.posStep)  pos <= pos + OFF_W'(1);
  end

  assign stat.skipOne    = (skipCnt == SKIP_W'(1));
  assign stat.fieldsDone = (fieldCnt == FLD_W'(NUM_FIELDS));
  assign stat.runAtEnd   = (runCnt == RUN_W'(SYNC_LEN - 1));
  assign stat.pendOne    = (pendCnt == PEND_W'(1));
  assign stat.lastPend   = lastPend;

  // R2: control only counts down while more than one byte is left
  p_skip_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl.skipDec |-> (skipCnt > SKIP_W'(1)));

  // R3: never more fields than configured
  p_field_bound_r3: assert property (@(posedge clk) disable iff (rst)
    fieldCnt <= FLD_W'(NUM_FIELDS));

  // R4: run count never steps past the match point
  p_run_bound_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl.runInc |-> (runCnt < RUN_W'(SYNC_LEN - 1)));

  // R5: held bytes are released only while some remain
  p_pend_drain_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl.pendDec |-> (pendCnt != '0));

endmodule

// File: rtl/hs_control.sv
module hs_control
  import header_skipper_pkg::*;
#(
  parameter logic [7:0] SYNC_BYTE = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       outLast,
  input  logic       outReady,
  output logic       offsetValid,
  output logic       noPreamble,
  input  dpStat_t    stat,
  output dpCtrl_t    ctrl
);

  skipState_e state, nxtState;
  logic       setErr;

  always_comb begin
    ctrl     = '0;
    nxtState = state;
    setErr   = 1'b0;
    inReady  = 1'b0;
    outValid = 1'b0;
    outData  = inData;
    outLast  = inLast;
    unique case (state)
      ST_SKIP: begin
        inReady = 1'b1;
        if (inValid) begin
          ctrl.posStep = 1'b1;
          if (inLast) begin
            setErr = 1'b1;
          end else if (stat.skipOne) begin
            nxtState = stat.fieldsDone ? ST_SCAN : ST_LEN;
          end else begin
            ctrl.skipDec = 1'b1;
          end
        end
      end
      ST_LEN: begin
        inReady = 1'b1;
        if (inValid) begin
          ctrl.posStep = 1'b1;
          if (inLast) begin
            setErr = 1'b1;
          end else begin
            ctrl.loadField = 1'b1;
            nxtState       = ST_SKIP;
          end
        end
      end
      ST_SCAN: begin
        inReady = 1'b1;
        if (inValid) begin
          ctrl.posStep = 1'b1;
          if (inData == SYNC_BYTE && stat.runAtEnd) begin
            ctrl.capture = 1'b1;
            ctrl.runClr  = 1'b1;
            ctrl.posClr  = inLast;
            nxtState     = ST_DRAIN;
          end else if (inLast) begin
            setErr = 1'b1;
          end else if (inData == SYNC_BYTE) begin
            ctrl.runInc = 1'b1;
          end else begin
            ctrl.runClr = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        outValid = 1'b1;
        outData  = SYNC_BYTE;
        outLast  = stat.lastPend && stat.pendOne;
        if (outReady) begin
          ctrl.pendDec = 1'b1;
          if (stat.pendOne) begin
            ctrl.restart = stat.lastPend;
            nxtState     = stat.lastPend ? ST_SKIP : ST_PASS;
          end
        end
      end
      ST_PASS: begin
        outValid = inValid;
        inReady  = outReady;
        if (inValid && outReady) begin
          ctrl.posStep = 1'b1;
          if (inLast) begin
            ctrl.posClr  = 1'b1;
            ctrl.restart = 1'b1;
            nxtState     = ST_SKIP;
          end
        end
      end
      default: nxtState = ST_SKIP;
    endcase
    if (setErr) begin
      ctrl.restart = 1'b1;
      ctrl.posClr  = 1'b1;
      ctrl.runClr  = 1'b1;
      nxtState     = ST_SKIP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SKIP;
      noPreamble <= 1'b0;
    end else begin
      state <= nxtState;
      if (setErr) noPreamble <= 1'b1;
    end
  end

  assign offsetValid = (state == ST_DRAIN) || (state == ST_PASS);

  // R8: a stalled output byte is held
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R7: error flag is sticky
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    noPreamble |=> noPreamble);

  // R7: a file that raised the error never reached forwarding
  p_err_silent_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(noPreamble) |-> !offsetValid);

endmodule

// File: rtl/header_skipper.sv
module header_skipper
  import header_skipper_pkg::*;
#(
  parameter int         PREFIX_LEN  = 15,
  parameter int         NUM_FIELDS  = 4,
  parameter int         FIELD_EXTRA = 3,
  parameter int         SYNC_LEN    = 4,
  parameter logic [7:0] SYNC_BYTE   = 8'hFF,
  parameter int         OFF_W       = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic [7:0]       outData,
  output logic             outValid,
  output logic             outLast,
  input  logic             outReady,
  output logic [OFF_W-1:0] startOffset,
  output logic             offsetValid,
  output logic             noPreamble
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  hs_control #(
    .SYNC_BYTE(SYNC_BYTE)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outLast(outLast), .outReady(outReady),
    .offsetValid(offsetValid), .noPreamble(noPreamble),
    .stat(stat), .ctrl(ctrl)
  );

  hs_datapath #(
    .PREFIX_LEN(PREFIX_LEN), .NUM_FIELDS(NUM_FIELDS), .FIELD_EXTRA(FIELD_EXTRA),
    .SYNC_LEN(SYNC_LEN), .OFF_W(OFF_W)
  ) u_dp (
    .clk(clk), .rst(rst),
    .inData(inData), .inLast(inLast),
    .ctrl(ctrl), .stat(stat), .startOffset(startOffset)
  );

endmodule

// File: tb/header_skipper_tb_top.sv
module header_skipper_tb_top;

  localparam int PREFIX  = 15;
  localparam int NFIELDS = 4;
  localparam int EXTRA   = 3;
  localparam int SLEN    = 4;
  localparam int OW      = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic [7:0]    inData;
  logic          inValid, inLast, inReady;
  logic [7:0]    outData;
  logic          outValid, outLast, outReady;
  logic [OW-1:0] startOffset;
  logic          offsetValid, noPreamble;

  always #10 clk = ~clk;

  header_skipper dut_i (
    .clk(clk), .rst(rst),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outLast(outLast), .outReady(outReady),
    .startOffset(startOffset), .offsetValid(offsetValid), .noPreamble(noPreamble)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit errSeen = 0;
  logic [7:0] fileQ[$];
  logic [7:0] expQ[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic addHeader(input int l0, input int l1, input int l2, input int l3,
                           input logic [7:0] fill);
    int lens[4];
    lens = '{l0, l1, l2, l3};
    fileQ = {};
    for (int i = 0; i < PREFIX; i++) fileQ.push_back(fill);
    for (int f = 0; f < NFIELDS; f++) begin
      fileQ.push_back(8'(lens[f]));
      for (int k = 0; k < lens[f] + EXTRA - 1; k++) fileQ.push_back(fill);
    end
  endtask

  task automatic addBytes(input logic [7:0] v, input int cnt);
    for (int i = 0; i < cnt; i++) fileQ.push_back(v);
  endtask

  task automatic addPayload(input int cnt, input int seed);
    for (int i = 0; i < cnt; i++) fileQ.push_back(8'((i * 7 + seed) & 8'h7F));
  endtask

  // mode 0: free flowing; mode 1: input gaps and output stalls
  task automatic runFile(input int mode, input string name);
    int n, p, found, idx, t, outCnt, expCnt;
    bit holding, prevStall, ok;
    logic [7:0] prevData, e;
    n = fileQ.size();
    p = PREFIX;
    for (int f = 0; f < NFIELDS; f++)
      if (p < n) p = p + int'(fileQ[p]) + EXTRA;
    found = -1;
    for (int i = p; i + SLEN <= n && found < 0; i++) begin
      ok = 1;
      for (int k = 0; k < SLEN; k++) if (fileQ[i+k] != 8'hFF) ok = 0;
      if (ok) found = i;
    end
    expQ = {};
    if (found >= 0) for (int i = found; i < n; i++) expQ.push_back(fileQ[i]);
    else errSeen = 1;
    expCnt = expQ.size();
    idx = 0; t = 0; outCnt = 0; holding = 0; prevStall = 0; prevData = '0;
    while ((idx < n || expQ.size() > 0) && t < 20000) begin
      @(negedge clk);
      t++;
      outReady = (mode == 0) ? 1'b1 : ((t % 3) != 0);
      if (idx < n) begin
        inValid = holding || (mode == 0) || ((t % 4) != 1);
        inData  = fileQ[idx];
        inLast  = (idx == n - 1);
      end else begin
        inValid = 1'b0;
        inLast  = 1'b0;
      end
      #1;
      if (prevStall)
        chk(outValid && outData == prevData, {"R8 hold ", name}, {outValid, outData}, {1'b1, prevData});
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (outValid && outReady) begin
        outCnt++;
        if (expQ.size() == 0) begin
          chk(0, {"R1 unexpected byte ", name}, outData, 0);
        end else begin
          e = expQ.pop_front();
          chk(outData == e, {"R5 data ", name}, outData, e);
          chk(outLast == (expQ.size() == 0), {"R9 last ", name}, outLast, expQ.size() == 0);
          chk(offsetValid && startOffset == OW'(found), {"R6 offset ", name}, startOffset, found);
        end
      end else if (outValid && expQ.size() == 0) begin
        chk(0, {"R1 early valid ", name}, outData, 0);
      end
      holding = inValid && !inReady;
      if (inValid && inReady) idx++;
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; outReady = 1'b1;
    #1;
    chk(outCnt == expCnt, {"R1 byte count ", name}, outCnt, expCnt);
    chk(noPreamble == errSeen, {"R7 sticky flag ", name}, noPreamble, errSeen);
    chk(!offsetValid && !outValid && inReady, {"R9 idle after file ", name},
        {offsetValid, outValid, inReady}, 3'b001);
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; inLast = 1'b0; inData = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(inReady && !outValid && !offsetValid && !noPreamble, "R10 reset state",
        {inReady, outValid, offsetValid, noPreamble}, 4'b1000);

    // plain file, R2 R3 field walk with small lengths
    addHeader(3, 0, 5, 2, 8'h41); addBytes(8'h00, 1); addBytes(8'h12, 1);
    addBytes(8'hFF, 4); addPayload(10, 1);
    runFile(0, "basic");

    // header full of 0xFF plus a broken run before the real one, R4
    addHeader(1, 4, 0, 6, 8'hFF); addBytes(8'hFF, 3); addBytes(8'h00, 1);
    addBytes(8'hFF, 1); addBytes(8'h33, 1); addBytes(8'hFF, 4); addPayload(20, 3);
    runFile(1, "false-run");

    // longest field length and a six-byte run, R2 R4
    addHeader(255, 2, 2, 2, 8'hFF); addBytes(8'hFF, 6); addPayload(5, 9);
    runFile(1, "long-field");

    // file ends on the last sync byte, R9
    addHeader(0, 0, 0, 0, 8'h5A); addBytes(8'hFF, 4);
    runFile(1, "sync-at-end");

    // ends while scanning, R7
    addHeader(2, 2, 2, 2, 8'h10); addBytes(8'h01, 2); addBytes(8'hFF, 3); addBytes(8'h00, 1);
    runFile(0, "no-sync");

    // normal file after the error, R7 recovery
    addHeader(4, 1, 3, 0, 8'h20); addBytes(8'hFF, 4); addPayload(12, 5);
    runFile(1, "after-error");

    // ends inside the prefix, R7
    fileQ = {};
    addBytes(8'hFF, 10);
    runFile(0, "short");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule